// File: doc/BRIEF.md
# Crypto Request Stream Sequence Checker

This block watches the request stream that feeds a symmetric cipher engine and flags beats that break the ordering and framing rules the engine depends on. Each accepted beat carries block and packet markers, a last-data marker, a cipher mode and a beat kind (key, IV/tweak, data, or a reserved value). The checker remembers whether a key has ever been loaded and whether the current packet has seen its IV. It counts the beats of each packet against a length limit and keeps a sliding record of recent block starts to limit how many ciphertext-stealing (CTS) requests arrive close together. It also compares each requested mode against hardware enable straps.

When a beat breaks a rule, the checker raises a one-cycle error pulse with a 5-bit code on the clock edge that follows the beat. A packet reports at most one error. After that error the checker ignores the rest of the packet, up to and including its end-of-packet beat. The engine itself is not part of this block. The checker only observes the stream and never stalls it.

Top module: `crypto_req_seq_check`

## Requirements
- R1: After reset, `err_valid` is low, `err_code` is 0, no key counts as loaded, and no block or packet is open.
- R2: A beat is examined only in a cycle where `in_valid` and `in_ready` are both high. Its result appears on `err_valid`/`err_code` after the next rising clock edge and lasts one cycle. `err_code` is 0 whenever `err_valid` is low.
- R3: `in_kind` encodes 0 = key, 1 = IV/tweak, 2 = data, 3 = reserved. A data beat with `in_eob` set, `in_sob` clear and no open block gives code 0x02. Any other data beat with `in_sob` clear and no open block gives code 0x01. A data beat with `in_sob` opens a block, and a data beat with `in_eob` or `in_eop` closes it.
- R4: `in_mode` encodes 0 = AES, 1 = SM4, 2 = XTS, 3 = CTS. A key, IV or data beat whose mode has its strap low gives 0x13 for AES (`en_aes`), 0x12 for SM4 (`en_sm4`) or 0x14 for XTS (`en_xts`). CTS has no strap.
- R5: A data beat that arrives before any key beat has been accepted without error since reset gives code 0x17.
- R6: A data beat in a packet with no IV beat so far, counting the current beat, gives code 0x19 when `in_proto` is 1 (IPsec) or 2 (MACsec). For `in_proto` 0 or 3 (generic GCM/XTS) it gives code 0x18.
- R7: The beat that brings a packet's length to `MAX_LEN` beats without `in_eop` gives code 0x1B when `in_proto` is 2 and 0x1A otherwise. The count restarts at 1 on the first beat of a packet.
- R8: A data beat with `in_eop` set, mode XTS or CTS, and `in_last` clear gives code 0x1C.
- R9: A data beat with `in_sob` and mode CTS gives code 0x09 if the previous `CTS_WIN`-1 error-free block starts already hold `CTS_LIMIT` CTS blocks.
- R10: A beat of the reserved kind 3 gives code 0x1F.
- R11: If several rules fail on one beat, one code is reported, chosen in this order: 0x1F, 0x02, 0x01, mode (0x12/0x13/0x14), 0x17, 0x18/0x19, 0x09, 0x1C, 0x1A/0x1B. A beat that raises an error changes no key, IV, block or CTS state.
- R12: After an error on a beat without `in_eop`, every later beat is ignored up to and including the next beat with `in_eop`. The following beat starts a fresh packet. An error on a beat with `in_eop` ends that packet with no ignored beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat offered on the stream |
| in_ready | input | 1 | Beat taken by the engine |
| in_sob | input | 1 | Start of block |
| in_eob | input | 1 | End of block |
| in_eop | input | 1 | End of packet |
| in_last | input | 1 | Last-data marker for XTS/CTS |
| in_mode | input | 2 | Cipher mode: 0 AES, 1 SM4, 2 XTS, 3 CTS |
| in_kind | input | 2 | Beat kind: 0 key, 1 IV/tweak, 2 data, 3 reserved |
| in_proto | input | 2 | Pattern: 0 generic, 1 IPsec, 2 MACsec, 3 generic |
| en_aes | input | 1 | AES available strap |
| en_sm4 | input | 1 | SM4 available strap |
| en_xts | input | 1 | XTS available strap |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 5 | Error code, 0 when no pulse |

## Verification
Every result is due exactly one rising edge after the beat that causes it. The bench applies a beat at a falling edge and, at the next falling edge, compares both outputs with the prediction its reference model made for that beat, before it applies the following beat. Cycles with no handshake are compared the same way and must show no pulse, which covers ignored and locked-out beats. Directed packets reach each code, the priority order, the lock release on end-of-packet and the CTS window edge. A long run of random beats then mixes the rules together.

// File: rtl/crypto_req_seq_check.sv
module crypto_req_seq_check #(
  parameter int MAX_LEN   = 8,
  parameter int CTS_WIN   = 16,
  parameter int CTS_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_ready,
  input  logic       in_sob,
  input  logic       in_eob,
  input  logic       in_eop,
  input  logic       in_last,
  input  logic [1:0] in_mode,
  input  logic [1:0] in_kind,
  input  logic [1:0] in_proto,
  input  logic       en_aes,
  input  logic       en_sm4,
  input  logic       en_xts,
  output logic       err_valid,
  output logic [4:0] err_code
);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int HW = CTS_WIN - 1;

  logic          key_ok, in_pkt, iv_seen, blk_open, locked;
  logic [LW-1:0] len_q;
  logic [HW-1:0] cts_hist;
  logic          hit;
  logic [4:0]    code;

  wire fire     = in_valid & in_ready;
  wire is_key   = in_kind == 2'd0;
  wire is_iv    = in_kind == 2'd1;
  wire is_data  = in_kind == 2'd2;
  wire is_rsv   = in_kind == 2'd3;
  wire is_cts   = in_mode == 2'd3;
  wire xts_cts  = in_mode[1];
  wire macsec   = in_proto == 2'd2;
  wire secproto = in_proto == 2'd1 || in_proto == 2'd2;

  wire [LW-1:0] len_now = in_pkt ? len_q + 1'b1 : LW'(1);
  wire          iv_now  = (in_pkt & iv_seen) | is_iv;
  wire          mode_off = (in_mode == 2'd0 && !en_aes) ||
                           (in_mode == 2'd1 && !en_sm4) ||
                           (in_mode == 2'd2 && !en_xts);
  wire [4:0]    mode_code = in_mode == 2'd1 ? 5'h12 :
                            in_mode == 2'd0 ? 5'h13 : 5'h14;
  wire          cts_full = $countones(cts_hist) >= CTS_LIMIT;

  always_comb begin
    hit  = 1'b1;
    code = 5'h00;
    if (is_rsv)                                           code = 5'h1F;
    else if (is_data && in_eob && !in_sob && !blk_open)   code = 5'h02;
    else if (is_data && !in_sob && !blk_open)             code = 5'h01;
    else if (mode_off)                                    code = mode_code;
    else if (is_data && !key_ok)                          code = 5'h17;
    else if (is_data && !iv_now)                          code = secproto ? 5'h19 : 5'h18;
    else if (is_data && in_sob && is_cts && cts_full)     code = 5'h09;
    else if (is_data && in_eop && xts_cts && !in_last)    code = 5'h1C;
    else if (len_now == LW'(MAX_LEN) && !in_eop)          code = macsec ? 5'h1B : 5'h1A;
    else                                                  hit  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 5'h00;
      key_ok    <= 1'b0;
      in_pkt    <= 1'b0;
      iv_seen   <= 1'b0;
      blk_open  <= 1'b0;
      locked    <= 1'b0;
      len_q     <= '0;
      cts_hist  <= '0;
    end else begin
      err_valid <= 1'b0;
      err_code  <= 5'h00;
      if (fire) begin
        if (locked) begin
          if (in_eop) begin
            locked   <= 1'b0;
            in_pkt   <= 1'b0;
            iv_seen  <= 1'b0;
            blk_open <= 1'b0;
            len_q    <= '0;
          end
        end else begin
          err_valid <= hit;
          err_code  <= code;
          if (in_eop) begin
            in_pkt   <= 1'b0;
            iv_seen  <= 1'b0;
            blk_open <= 1'b0;
            len_q    <= '0;
          end else if (hit) begin
            locked   <= 1'b1;
            blk_open <= 1'b0;
          end else begin
            in_pkt   <= 1'b1;
            len_q    <= len_now;
            iv_seen  <= iv_now;
            if (is_data) blk_open <= (blk_open | in_sob) & ~in_eob;
          end
          if (!hit) begin
            if (is_key) key_ok <= 1'b1;
            if (is_data && in_sob) cts_hist <= {cts_hist[HW-2:0], is_cts};
          end
        end
      end
    end
  end
endmodule

module crypto_req_seq_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sob,
  input logic       in_eop,
  input logic [1:0] in_mode,
  input logic [1:0] in_kind,
  input logic       en_aes,
  input logic       en_sm4,
  input logic       err_valid,
  input logic [4:0] err_code
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !err_valid);
  a_r2_only_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(in_valid && in_ready));
  a_r2_code_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |-> err_code == 5'h00);
  a_r3_no_sob: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 5'h01) |-> $past(in_kind == 2'd2 && !in_sob));
  a_r4_aes_strap: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 5'h13) |-> $past(!en_aes && in_mode == 2'd0));
  a_r4_sm4_strap: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 5'h12) |-> $past(!en_sm4 && in_mode == 2'd1));
  a_r10_reserved_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 5'h1F) |-> $past(in_kind == 2'd3));
  a_r12_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !$past(in_eop)) |=> !err_valid);
endmodule

bind crypto_req_seq_check crypto_req_seq_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sob(in_sob), .in_eop(in_eop), .in_mode(in_mode), .in_kind(in_kind),
  .en_aes(en_aes), .en_sm4(en_sm4), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/crypto_req_seq_check_tb.sv
`timescale 1ns/1ps
module crypto_req_seq_check_tb;
  localparam int MAXL = 8;
  localparam int WIN  = 16;
  localparam int LIM  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_ready = 0, in_sob = 0, in_eob = 0, in_eop = 0, in_last = 0;
  logic [1:0] in_mode = 0, in_kind = 0, in_proto = 0;
  logic en_aes = 1, en_sm4 = 1, en_xts = 1;
  logic err_valid;
  logic [4:0] err_code;

  int checks = 0, errors = 0;
  bit done = 0;
  int p_proto = 0;
  bit p_aes = 1, p_sm4 = 1, p_xts = 1;
  string cur_req = "R1";

  int m_key, m_pkt, m_iv, m_blk, m_lock, m_len;
  int hist[$];
  int exp_code = 0;

  crypto_req_seq_check #(.MAX_LEN(MAXL), .CTS_WIN(WIN), .CTS_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sob(in_sob), .in_eob(in_eob), .in_eop(in_eop), .in_last(in_last),
    .in_mode(in_mode), .in_kind(in_kind), .in_proto(in_proto),
    .en_aes(en_aes), .en_sm4(en_sm4), .en_xts(en_xts),
    .err_valid(err_valid), .err_code(err_code));

  always #2 clk = ~clk;

  function automatic string tag(input int c);
    case (c)
      'h01, 'h02: return "R3";
      'h12, 'h13, 'h14: return "R4";
      'h17: return "R5";
      'h18, 'h19: return "R6";
      'h1A, 'h1B: return "R7";
      'h1C: return "R8";
      'h09: return "R9";
      'h1F: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_key = 0; m_pkt = 0; m_iv = 0; m_blk = 0; m_lock = 0; m_len = 0;
    hist.delete();
    exp_code = 0;
  endtask

  task automatic model(input bit v, r, sob, eob, eop, last, input int mode, kind, output int code);
    int len_now, cnt;
    bit iv_now, off;
    code = 0;
    if (!(v && r)) return;
    if (m_lock != 0) begin
      if (eop) begin m_lock = 0; m_pkt = 0; m_len = 0; m_iv = 0; m_blk = 0; end
      return;
    end
    len_now = (m_pkt != 0) ? m_len + 1 : 1;
    iv_now  = (m_pkt != 0 && m_iv != 0) || kind == 1;
    cnt = 0;
    foreach (hist[i]) cnt += hist[i];
    off = (mode == 0 && !p_aes) || (mode == 1 && !p_sm4) || (mode == 2 && !p_xts);
    if (kind == 3) code = 'h1F;
    else if (kind == 2 && eob && !sob && m_blk == 0) code = 'h02;
    else if (kind == 2 && !sob && m_blk == 0) code = 'h01;
    else if (off) code = (mode == 1) ? 'h12 : (mode == 0) ? 'h13 : 'h14;
    else if (kind == 2 && m_key == 0) code = 'h17;
    else if (kind == 2 && !iv_now) code = (p_proto == 1 || p_proto == 2) ? 'h19 : 'h18;
    else if (kind == 2 && sob && mode == 3 && cnt + 1 > LIM) code = 'h09;
    else if (kind == 2 && eop && mode >= 2 && !last) code = 'h1C;
    else if (len_now >= MAXL && !eop) code = (p_proto == 2) ? 'h1B : 'h1A;
    if (eop) begin m_pkt = 0; m_len = 0; m_iv = 0; m_blk = 0; end
    else if (code != 0) m_lock = 1;
    else begin m_pkt = 1; m_len = len_now; m_iv = iv_now; end
    if (code == 0) begin
      if (kind == 0) m_key = 1;
      if (kind == 2 && !eop) m_blk = ((m_blk != 0) || sob) && !eob;
      if (kind == 2 && sob) begin
        hist.push_back(mode == 3 ? 1 : 0);
        if (hist.size() > WIN - 1) void'(hist.pop_front());
      end
    end
  endtask

  task automatic compare();
    int ev;
    ev = (exp_code != 0) ? 1 : 0;
    checks++;
    if (err_valid !== ev[0] || err_code !== exp_code[4:0]) begin
      errors++;
      $display("FAIL %s/%s: err_valid=%0b err_code=0x%02h expected valid=%0b code=0x%02h",
               cur_req, tag(exp_code), err_valid, err_code, ev[0], exp_code[4:0]);
    end
  endtask

  task automatic beat(input bit v, r, sob, eob, eop, last, input int mode, kind);
    int c;
    @(negedge clk);
    compare();
    in_valid = v; in_ready = r; in_sob = sob; in_eob = eob; in_eop = eop; in_last = last;
    in_mode = mode[1:0]; in_kind = kind[1:0]; in_proto = p_proto[1:0];
    en_aes = p_aes; en_sm4 = p_sm4; en_xts = p_xts;
    model(v, r, sob, eob, eop, last, mode, kind, c);
    exp_code = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic key(input int mode);  beat(1, 1, 0, 0, 0, 0, mode, 0); endtask
  task automatic iv(input int mode);   beat(1, 1, 0, 0, 0, 0, mode, 1); endtask
  task automatic data(input bit sob, eob, eop, last, input int mode);
    beat(1, 1, sob, eob, eop, last, mode, 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    checks++;
    if (err_valid !== 1'b0 || err_code !== 5'h00) begin
      errors++;
      $display("FAIL R1: reset outputs %0b/0x%02h expected 0/0x00", err_valid, err_code);
    end
    rst_n = 1'b1;
    idle(2);

    cur_req = "R5";
    iv(0); data(1, 1, 1, 1, 0);
    cur_req = "R2";
    beat(1, 0, 0, 0, 0, 0, 0, 3);
    beat(0, 1, 0, 0, 0, 0, 0, 3);
    idle(1);

    key(0); iv(0); data(1, 0, 0, 0, 0); data(0, 0, 0, 0, 0); data(0, 1, 1, 0, 0);
    idle(1);

    cur_req = "R3";
    iv(0); data(0, 0, 0, 0, 0); data(0, 0, 1, 0, 0);
    iv(0); data(0, 1, 1, 0, 0);
    iv(0); data(1, 1, 0, 0, 0); data(0, 0, 1, 0, 0);

    cur_req = "R4";
    p_sm4 = 0; iv(1); data(1, 1, 1, 1, 1);
    p_sm4 = 1; p_aes = 0; key(0); data(0, 0, 1, 0, 0);
    p_aes = 1; p_xts = 0; iv(2); data(0, 0, 1, 0, 2);
    iv(3); data(1, 1, 1, 1, 3);
    p_xts = 1;

    cur_req = "R6";
    p_proto = 0; data(1, 1, 1, 0, 0);
    p_proto = 2; data(1, 1, 1, 0, 0);
    p_proto = 1; key(0); data(1, 0, 0, 0, 0); data(0, 0, 1, 0, 0);

    cur_req = "R7";
    p_proto = 0; iv(0);
    for (int i = 0; i < MAXL - 1; i++) data(i == 0, 0, 0, 0, 0);
    data(0, 0, 1, 0, 0);
    p_proto = 2; iv(0);
    for (int i = 0; i < MAXL - 1; i++) data(i == 0, 0, 0, 0, 0);
    data(0, 0, 1, 0, 0);
    p_proto = 0; iv(0);
    for (int i = 0; i < MAXL - 2; i++) data(i == 0, 0, 0, 0, 0);
    data(0, 1, 1, 0, 0);

    cur_req = "R8";
    iv(2); data(1, 1, 1, 0, 2);
    iv(2); data(1, 1, 1, 1, 2);
    iv(3); data(1, 1, 1, 0, 3);

    cur_req = "R9";
    for (int i = 0; i < 12; i++) begin iv(0); data(1, 1, 1, 1, 0); end
    for (int i = 0; i < 5; i++) begin iv(3); data(1, 1, 1, 1, 3); end
    for (int i = 0; i < 12; i++) begin iv(0); data(1, 1, 1, 1, 0); end
    iv(3); data(1, 1, 1, 1, 3);

    cur_req = "R10";
    beat(1, 1, 0, 0, 0, 0, 0, 3); beat(1, 1, 0, 0, 1, 0, 0, 3);
    beat(1, 1, 0, 0, 1, 0, 0, 3);

    cur_req = "R11";
    p_aes = 0; data(0, 0, 1, 0, 0);
    data(1, 1, 1, 1, 0);
    p_aes = 1; beat(1, 1, 0, 1, 0, 0, 0, 3);
    beat(1, 1, 0, 0, 1, 0, 0, 0);

    cur_req = "R12";
    data(0, 0, 0, 0, 0);
    beat(1, 1, 0, 0, 0, 0, 0, 3); data(0, 1, 0, 0, 0); beat(0, 0, 0, 0, 1, 0, 0, 2);
    data(0, 0, 1, 0, 0);
    iv(0); data(1, 1, 1, 1, 0);
    idle(1);

    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int k, m, pr;
      k  = ($urandom % 8 == 0) ? 3 : $urandom % 3;
      m  = $urandom % 4;
      pr = $urandom % 4;
      p_proto = pr;
      p_aes = ($urandom % 16) != 0;
      p_sm4 = ($urandom % 16) != 0;
      p_xts = ($urandom % 16) != 0;
      beat(($urandom % 8) != 0, ($urandom % 8) != 0, $urandom % 3 == 0, $urandom % 3 == 0,
           $urandom % 4 == 0, $urandom % 2 == 0, m, (k == 0 && $urandom % 2 == 0) ? 2 : k);
    end
    idle(2);

    cur_req = "R1";
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    checks++;
    if (err_valid !== 1'b0 || err_code !== 5'h00) begin
      errors++;
      $display("FAIL R1: reset outputs %0b/0x%02h expected 0/0x00", err_valid, err_code);
    end
    rst_n = 1'b1;
    cur_req = "R5";
    iv(0); data(1, 1, 1, 1, 0);
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule